// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Register Unit

This block holds the bank registers of a cartridge memory mapper. The CPU's upper 32 KB window is split into four 8 KB program slots, and the PPU's 8 KB pattern space into eight 1 KB character slots. The unit turns the address of the current access into a bank number for each of the two memories. It also holds the nametable mirroring mode and flags CPU accesses that fall in an 8 KB work-RAM window. The memories themselves and any interrupt timer sit outside the block.

Program registers are loaded indirectly. A write to the `$E000` page sets a 3-bit index. A later write anywhere in the `$F000` page loads the program register that the index names. The same write to the `$F000` page is also decoded on address bits [15:10], so in one cycle it can also set a program high bank bit, the mirroring mode or a character register. All outputs are combinational functions of the registers and the current addresses. A register write becomes visible on the outputs right after the clock edge that takes it.

Top module: `prg_chr_bank_regs`

## Requirements
- R1: After a synchronous active-low reset, all four program high bits are 1, the three program registers, eight character registers and the select index are 0, and mirroring is vertical (`mirror_vert`=1).
- R2: A write with `cpu_addr[15:12]`=4'hE stores `cpu_data[2:0]` as the select index; the upper data bits are discarded.
- R3: A write with `cpu_addr[15:12]`=4'hF stores `cpu_data[3:0]` into program register 0, 1 or 2 when the index is 1, 2 or 3; indices 0 and 4-7 load no program register.
- R4: A write with `cpu_addr[15:10]`=6'b111100 stores `cpu_data[3]` as the high bank bit of slot `cpu_addr[1:0]`, in the same cycle as any R3 update.
- R5: A write with `cpu_addr[15:10]`=6'b111110 sets mirroring from `cpu_data[0]`: 0 is horizontal, 1 is vertical.
- R6: A write with `cpu_addr[15:10]`=6'b111111 stores `cpu_data[6:0]` into character register `cpu_addr[2:0]`.
- R7: `prg_bank` is taken from the slot named by `cpu_addr[14:13]`. For slots 0-2 it is {high bit, 4-bit register}. For slot 3 it is the smaller of {high bit of slot 3, 4'b1111} and `PRG_BANKS`-1.
- R8: `chr_bank` is the character register indexed by `ppu_addr[12:10]`.
- R9: `wram_sel` is 1 exactly when `cpu_addr` lies in `$6000`-`$7FFF`.
- R10: A cycle with `cpu_wr`=0, or a write below `$E000` (including `$6000`-`$DFFF`), changes no bank register and does not change mirroring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| ppu_addr | input | 14 | PPU address |
| prg_bank | output | 5 | 8 KB program bank for the slot addressed by `cpu_addr` |
| chr_bank | output | 7 | 1 KB character bank for the slot addressed by `ppu_addr` |
| wram_sel | output | 1 | Work-RAM window select |
| mirror_vert | output | 1 | Mirroring mode, 1 vertical, 0 horizontal |

## Verification
A write is captured at the rising edge where `cpu_wr` is high. Its effect on `prg_bank`, `chr_bank` and `mirror_vert` is due after that edge with no further register stage. `wram_sel` and the slot lookups depend only on the current addresses, within the same cycle. The bench drives each write on a falling edge and drops the strobe on the next falling edge. It then moves the probe addresses and samples a moment later, so every check reads settled combinational outputs one edge after the write. The checker's properties look exactly one cycle after a write.

// File: rtl/bank_pkg.sv
// Package: shared widths, mirroring encoding and write-strobe bundle for
// the bank register unit. Assumes a 16-bit CPU bus and a 14-bit PPU bus.
package bank_pkg;

    localparam int CPU_AW      = 16;
    localparam int PPU_AW      = 14;
    localparam int DATA_W      = 8;
    localparam int PRG_REG_W   = 4;
    localparam int PRG_BW      = PRG_REG_W + 1;
    localparam int CHR_REG_W   = 7;
    localparam int SEL_W       = 3;
    localparam int N_PRG_SLOTS = 4;
    localparam int N_IDX_REGS  = 3;
    localparam int N_CHR_SLOTS = 8;
    localparam int PRG_SLOT_AW = $clog2(N_PRG_SLOTS);
    localparam int CHR_SLOT_AW = $clog2(N_CHR_SLOTS);

    typedef enum logic {
        MIR_HORZ = 1'b0,
        MIR_VERT = 1'b1
    } mirror_e;

    typedef struct packed {
        logic sel_we;    // index register load
        logic top_we;    // indexed program register load
        logic hibit_we;  // program high-bit load
        logic mir_we;    // mirroring load
        logic chr_we;    // character register load
    } wr_strobes_t;

endpackage

// File: rtl/bank_wr_decode.sv
// Module: bank_wr_decode
// Turns a CPU write into load strobes. The top-page strobes overlap on
// purpose: one write may raise top_we together with one sub-page strobe.
// Assumes cpu_wr is a single-cycle pulse per write.
module bank_wr_decode
    import bank_pkg::*;
(
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    output wr_strobes_t       strobes
);

    localparam logic [3:0] PAGE_SEL = 4'hE;
    localparam logic [3:0] PAGE_TOP = 4'hF;
    localparam logic [5:0] SUB_HI   = 6'b111100;
    localparam logic [5:0] SUB_MIR  = 6'b111110;
    localparam logic [5:0] SUB_CHR  = 6'b111111;

    logic [3:0] page;
    logic [5:0] sub;

    // Purpose: split the address into 4 KB page and 1 KB sub-page fields.
    always_comb begin
        page = cpu_addr[CPU_AW-1 -: 4];
        sub  = cpu_addr[CPU_AW-1 -: 6];
    end

    // Purpose: gate each decode with the write strobe.
    always_comb begin
        strobes.sel_we   = cpu_wr && (page == PAGE_SEL);
        strobes.top_we   = cpu_wr && (page == PAGE_TOP);
        strobes.hibit_we = cpu_wr && (sub == SUB_HI);
        strobes.mir_we   = cpu_wr && (sub == SUB_MIR);
        strobes.chr_we   = cpu_wr && (sub == SUB_CHR);
    end

endmodule

// File: rtl/prg_bank_map.sv
// Module: prg_bank_map
// Holds the select index, three indexed program registers and four high
// bank bits; maps the CPU slot to a program bank number, clamping the
// fixed last slot to the bank count. Assumes PRG_BANKS <= 2**PRG_BW.
module prg_bank_map
    import bank_pkg::*;
#(
    parameter int PRG_BANKS = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_strobes_t       strobes,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic [PRG_BW-1:0] prg_bank
);

    localparam logic [PRG_BW-1:0]    LAST_BANK = PRG_BW'(PRG_BANKS - 1);
    localparam logic [PRG_REG_W-1:0] ALL_ONES  = '1;
    localparam int                   HI_DBIT   = 3;

    logic [SEL_W-1:0]     sel_idx;
    logic [PRG_REG_W-1:0] prg_reg [N_IDX_REGS];
    logic                 hi_bit  [N_PRG_SLOTS];
    logic [PRG_BW-1:0]    slot_bank [N_PRG_SLOTS];
    logic [PRG_SLOT_AW-1:0] cpu_slot;

    // Purpose: load the select index from the index page.
    always_ff @(posedge clk) begin
        if (!rst_n)               sel_idx <= '0;
        else if (strobes.sel_we)  sel_idx <= cpu_data[SEL_W-1:0];
    end

    generate
        for (genvar g = 0; g < N_IDX_REGS; g++) begin : g_idx_reg
            // Purpose: load program register g when the index names it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    prg_reg[g] <= '0;
                else if (strobes.top_we && (sel_idx == SEL_W'(g + 1)))
                    prg_reg[g] <= cpu_data[PRG_REG_W-1:0];
            end
            // Purpose: bank for a switchable slot is {high bit, register}.
            always_comb slot_bank[g] = {hi_bit[g], prg_reg[g]};
        end

        for (genvar s = 0; s < N_PRG_SLOTS; s++) begin : g_hi_bit
            // Purpose: load the high bank bit of slot s from data bit 3.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hi_bit[s] <= 1'b1;
                else if (strobes.hibit_we &&
                         (cpu_addr[PRG_SLOT_AW-1:0] == PRG_SLOT_AW'(s)))
                    hi_bit[s] <= cpu_data[HI_DBIT];
            end
        end
    endgenerate

    logic [PRG_BW-1:0] fixed_raw;

    // Purpose: fixed last slot, limited to the last bank present.
    always_comb begin
        fixed_raw = {hi_bit[N_PRG_SLOTS-1], ALL_ONES};
        slot_bank[N_PRG_SLOTS-1] = (fixed_raw > LAST_BANK) ? LAST_BANK
                                                           : fixed_raw;
    end

    // Purpose: choose the bank of the slot under the CPU address.
    always_comb begin
        cpu_slot = cpu_addr[CPU_AW-2 -: PRG_SLOT_AW];
        prg_bank = slot_bank[cpu_slot];
    end

endmodule

// File: rtl/chr_bank_file.sv
// Module: chr_bank_file
// Eight 1 KB character bank registers, loaded by CPU writes and read out
// by the PPU slot index. Assumes one write per cycle at most.
module chr_bank_file
    import bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chr_we,
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_data,
    input  logic [PPU_AW-1:0]    ppu_addr,
    output logic [CHR_REG_W-1:0] chr_bank
);

    localparam int SLOT_LSB = 10;

    logic [CHR_REG_W-1:0]   chr_reg [N_CHR_SLOTS];
    logic [CHR_SLOT_AW-1:0] ppu_slot;

    generate
        for (genvar c = 0; c < N_CHR_SLOTS; c++) begin : g_chr_reg
            // Purpose: load character register c from the low data bits.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chr_reg[c] <= '0;
                else if (chr_we &&
                         (cpu_addr[CHR_SLOT_AW-1:0] == CHR_SLOT_AW'(c)))
                    chr_reg[c] <= cpu_data[CHR_REG_W-1:0];
            end
        end
    endgenerate

    // Purpose: select the register for the 1 KB slot the PPU addresses.
    always_comb begin
        ppu_slot = ppu_addr[SLOT_LSB +: CHR_SLOT_AW];
        chr_bank = chr_reg[ppu_slot];
    end

endmodule

// File: rtl/prg_chr_bank_regs.sv
// Module: prg_chr_bank_regs (top)
// Bank register unit: write decode, program bank map, character bank
// file, mirroring flag and work-RAM window select. Outputs are
// combinational from registers and current addresses.
module prg_chr_bank_regs
    import bank_pkg::*;
#(
    parameter int PRG_BANKS = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [15:0]             cpu_addr,
    input  logic [7:0]              cpu_data,
    input  logic                    cpu_wr,
    input  logic [13:0]             ppu_addr,
    output logic [4:0]              prg_bank,
    output logic [6:0]              chr_bank,
    output logic                    wram_sel,
    output logic                    mirror_vert
);

    localparam logic [2:0] WRAM_PAGE = 3'b011;

    wr_strobes_t strobes;
    mirror_e     mirror_q;

    bank_wr_decode u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .strobes  (strobes)
    );

    prg_bank_map #(.PRG_BANKS(PRG_BANKS)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobes  (strobes),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .prg_bank (prg_bank)
    );

    chr_bank_file u_chr (
        .clk      (clk),
        .rst_n    (rst_n),
        .chr_we   (strobes.chr_we),
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .ppu_addr (ppu_addr),
        .chr_bank (chr_bank)
    );

    // Purpose: hold the mirroring mode, loaded from data bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)              mirror_q <= MIR_VERT;
        else if (strobes.mir_we) mirror_q <= mirror_e'(cpu_data[0]);
    end

    // Purpose: drive the mirroring pin and the work-RAM window select.
    always_comb begin
        mirror_vert = (mirror_q == MIR_VERT);
        wram_sel    = (cpu_addr[15:13] == WRAM_PAGE);
    end

endmodule

// File: rtl/bank_regs_checker.sv
// Module: bank_regs_checker
// Port-level properties of the bank register unit, bound to the top.
module bank_regs_checker #(
    parameter int PRG_BANKS = 24
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        cpu_wr,
    input logic [13:0] ppu_addr,
    input logic [4:0]  prg_bank,
    input logic [6:0]  chr_bank,
    input logic        wram_sel,
    input logic        mirror_vert
);

    localparam logic [4:0] LAST_BANK = 5'(PRG_BANKS - 1);

    // R5: mirroring follows data bit 0 one edge after a sub-page write.
    assert_mirror_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:10] == 6'b111110)
        |=> (mirror_vert == $past(cpu_data[0])));

    // R10: no write, no mirroring change.
    assert_mirror_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(mirror_vert));

    // R10: no write and a steady PPU address keep the character bank.
    assert_chr_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> (ppu_addr != $past(ppu_addr) || $stable(chr_bank)));

    // R6: a character write is visible when the PPU reads that slot.
    assert_chr_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[15:10] == 6'b111111)
        |=> (ppu_addr[12:10] != $past(cpu_addr[2:0]) ||
             chr_bank == $past(cpu_data[6:0])));

    // R7: the fixed slot never points past the last bank present.
    assert_fixed_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b111) |-> (prg_bank <= LAST_BANK));

    // R9: a work-RAM select never coincides with a banked program access.
    assert_wram_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wram_sel |-> !cpu_addr[15]);

endmodule

bind prg_chr_bank_regs bank_regs_checker #(.PRG_BANKS(PRG_BANKS)) u_bank_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_addr    (cpu_addr),
    .cpu_data    (cpu_data),
    .cpu_wr      (cpu_wr),
    .ppu_addr    (ppu_addr),
    .prg_bank    (prg_bank),
    .chr_bank    (chr_bank),
    .wram_sel    (wram_sel),
    .mirror_vert (mirror_vert)
);

// File: tb/test_prg_chr_bank_regs.sv
// Bench: vector table of writes with expected probe results, then directed
// reset and window checks.
module test_prg_chr_bank_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic [4:0]  prg_bank;
    logic [6:0]  chr_bank;
    logic        wram_sel;
    logic        mirror_vert;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    prg_chr_bank_regs #(.PRG_BANKS(24)) i_prg_chr_bank_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_bank(prg_bank),
        .chr_bank(chr_bank), .wram_sel(wram_sel), .mirror_vert(mirror_vert)
    );

    typedef struct packed {
        logic [15:0] wa;
        logic [7:0]  wd;
        logic        we;
        logic [15:0] pa;
        logic [13:0] ppa;
        logic [4:0]  ep;
        logic [6:0]  ec;
        logic        em;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{16'hE000, 8'h01, 1'b1, 16'h8000, 14'h0000, 5'd16, 7'h00, 1'b1}, // R2 index only
        '{16'hF400, 8'h05, 1'b1, 16'h8000, 14'h0000, 5'd21, 7'h00, 1'b1}, // R3 reg0, no high bit
        '{16'hF000, 8'h03, 1'b1, 16'h8000, 14'h0000, 5'd3,  7'h00, 1'b1}, // R4 with R3 same write
        '{16'hE000, 8'h0A, 1'b1, 16'hA000, 14'h0000, 5'd16, 7'h00, 1'b1}, // R2 bits 2:0 only
        '{16'hF001, 8'h07, 1'b1, 16'hA000, 14'h0000, 5'd7,  7'h00, 1'b1},
        '{16'hE000, 8'h03, 1'b1, 16'hC000, 14'h0000, 5'd16, 7'h00, 1'b1},
        '{16'hF002, 8'h1E, 1'b1, 16'hC000, 14'h0000, 5'd30, 7'h00, 1'b1},
        '{16'hF003, 8'h00, 1'b1, 16'hE000, 14'h0000, 5'd15, 7'h00, 1'b1}, // R4 slot 3 high bit clear
        '{16'hF003, 8'h08, 1'b1, 16'hE000, 14'h0000, 5'd23, 7'h00, 1'b1}, // R7 clamp to 23
        '{16'hE000, 8'h00, 1'b1, 16'hC000, 14'h0000, 5'd24, 7'h00, 1'b1},
        '{16'hFC05, 8'hD5, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b1}, // R6 bit 7 dropped
        '{16'hFC02, 8'h7F, 1'b1, 16'h8000, 14'h0800, 5'd3,  7'h7F, 1'b1}, // R6
        '{16'hF800, 8'h00, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b0}, // R5 horizontal
        '{16'hF800, 8'h01, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b1}, // R5 vertical
        '{16'hF800, 8'h00, 1'b0, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b1}, // R10 no strobe
        '{16'hF800, 8'hFE, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b0}, // R5 bit 0 only
        '{16'h8000, 8'hFF, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b0}, // R10 low page
        '{16'hD000, 8'hFF, 1'b1, 16'hA000, 14'h1400, 5'd7,  7'h55, 1'b0}, // R10 low page
        '{16'hE000, 8'h04, 1'b1, 16'h8000, 14'h1400, 5'd3,  7'h55, 1'b0},
        '{16'hF000, 8'h0F, 1'b1, 16'h8000, 14'h1400, 5'd19, 7'h55, 1'b0}, // R3 index 4 loads none
        '{16'h6000, 8'h01, 1'b1, 16'h8000, 14'h1400, 5'd19, 7'h55, 1'b0}, // R10 RAM window
        '{16'hE000, 8'h07, 1'b1, 16'hA000, 14'h1C00, 5'd7,  7'h00, 1'b0},
        '{16'hFFFF, 8'h2A, 1'b1, 16'h8000, 14'h1C00, 5'd19, 7'h2A, 1'b0}  // R6 slot 7, R3 index 7
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input logic w);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = w;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [13:0] p);
        cpu_addr = a;
        ppu_addr = p;
        #1;
    endtask

    task automatic check_reset_state();
        probe(16'h8000, 14'h0000); chk("R1 slot0", prg_bank, 16);
        probe(16'hA000, 14'h0000); chk("R1 slot1", prg_bank, 16);
        probe(16'hC000, 14'h0000); chk("R1 slot2", prg_bank, 16);
        probe(16'hE000, 14'h0000); chk("R1 slot3", prg_bank, 23);
        chk("R1 mirror", mirror_vert, 1);
        for (int s = 0; s < 8; s++) begin
            probe(16'h8000, 14'(s * 1024));
            chk("R1 chr", chr_bank, 0);
        end
        // R1 index 0 after reset: a top-page write loads no register
        cpu_write(16'hF400, 8'h09, 1'b1);
        probe(16'h8000, 14'h0000); chk("R1 index", prg_bank, 16);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_reset_state();

        for (int i = 0; i < NV; i++) begin
            cpu_write(VECS[i].wa, VECS[i].wd, VECS[i].we);
            probe(VECS[i].pa, VECS[i].ppa);
            chk($sformatf("R7 vec %0d prg", i), prg_bank, VECS[i].ep);
            chk($sformatf("R8 vec %0d chr", i), chr_bank, VECS[i].ec);
            chk($sformatf("R5 vec %0d mirror", i), mirror_vert, VECS[i].em);
        end

        // R7 slot 3 still clamped; R8 other slots untouched
        probe(16'hFFFF, 14'h0000); chk("R7 fixed", prg_bank, 23);
        probe(16'h8000, 14'h0800); chk("R8 slot2", chr_bank, 7'h7F);
        probe(16'h8000, 14'h0400); chk("R8 slot1", chr_bank, 0);

        // R9 window edges
        probe(16'h5FFF, 14'h0); chk("R9 below", wram_sel, 0);
        probe(16'h6000, 14'h0); chk("R9 first", wram_sel, 1);
        probe(16'h7FFF, 14'h0); chk("R9 last", wram_sel, 1);
        probe(16'h8000, 14'h0); chk("R9 above", wram_sel, 0);

        // R1 reset in mid-run restores everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check_reset_state();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule